// File: doc/BRIEF.md
# Per-Thread Commit Squash Arbiter

At commit, several things can ask a thread to throw away work: a trap that has been counting down since a fault, a squash request from outside the thread's context, a deferred squash-after left by a committed instruction, and a branch or ordering squash from the execute stage. This block keeps a small control state per thread and a fixed priority among these sources. Each cycle it acts on at most one of them. It reports the result to the earlier stages as a squash pulse, a reorder-buffer-squashing flag, the sequence number through which work is kept, and a branch-taken hint.

Each thread holds the youngest sequence number still considered valid. Dispatched instructions advance it, and every squash resets it. An execute-stage squash that names an instruction younger than that point is stale and is dropped. A squash that clears the whole thread keeps everything older than the reorder buffer head. When the buffer is empty, it keeps everything up to the last committed instruction. Once a squash is taken, the thread stays in its squashing state until the reorder buffer reports that it has finished. During that time the squashing flag is raised every cycle.

Top module: `commit_squash_arb`

## Requirements
- R1: After reset, every thread is in state Idle and has no trap, context or squash-after request pending. The squash pulse, squashing flag, branch-taken flag, done sequence number and mispredict count are all zero.
- R2: The 3-bit thread state reads Idle=0, Running=1, ROBSquashing=2, TrapPending=3, FetchTrapPending=4 and SquashAfterPending=5. A dispatch moves Idle to Running. A squash-after request moves Running to SquashAfterPending.
- R3: A fault accepted at clock edge E sets trap-in-flight and state TrapPending. With a trap latency of L, the trap squash is taken at edge E+2+L, and that same edge clears trap-in-flight. A fault is ignored while a trap is already in flight.
- R4: When several sources want to act in the same cycle, the order is trap squash first, then context squash, then pending squash-after, then execute squash. Only one source acts per cycle. A pending squash-after is consumed by a context squash taken in its place.
- R5: A context squash request arriving while a trap is in flight, or in the same cycle as a fault, is dropped. The trap and context requests are never pending together.
- R6: An execute-stage squash is accepted only if the thread is not TrapPending and the squash sequence number is less than or equal to the youngest valid sequence number.
- R7: When include-self is set, the effective squash number is the given sequence number minus one. Otherwise it is the given number.
- R8: An accepted execute squash sets youngest to the effective number and moves the thread to ROBSquashing. On the next cycle it shows squash=1, squashing flag=1 and done sequence number equal to the effective number.
- R9: On an accepted execute squash, branch-taken equals the execute branch-taken input ORed with (mispredict AND unconditional). Each accepted squash that has both mispredict and unconditional set adds one to the mispredict count.
- R10: A whole-thread squash from the trap, context or squash-after source outputs head sequence minus one when the reorder buffer is not empty. Otherwise it outputs the last committed sequence number. In both cases youngest becomes the last committed sequence number.
- R11: In ROBSquashing, the squashing flag is raised on the cycle after each cycle in which the reorder buffer is not done. When the buffer reports done, the state returns to Running, and squash sources may act in that same cycle.
- R12: A dispatch in a cycle with no accepted squash sets youngest to the dispatched sequence number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapLatency | input | LAT_W | Cycles between a fault and its trap squash |
| faultValid | input | NUM_THREADS | Fault reported for the thread |
| ctxSquashReq | input | NUM_THREADS | Request from outside the context to squash the whole thread |
| squashAfterReq | input | NUM_THREADS | A committed instruction asks for a squash on the next cycle |
| exeSquash | input | NUM_THREADS | Squash request from the execute stage |
| exeSeq | input | NUM_THREADS*SEQ_W | Sequence number of the execute-stage squash |
| exeIncludeSelf | input | NUM_THREADS | Also squash the named instruction |
| exeMispredict | input | NUM_THREADS | Squash caused by a branch mispredict |
| exeUncond | input | NUM_THREADS | The mispredicted branch is unconditional |
| exeBranchTaken | input | NUM_THREADS | Taken direction reported by execute |
| dispValid | input | NUM_THREADS | Instruction dispatched into the reorder buffer |
| dispSeq | input | NUM_THREADS*SEQ_W | Sequence number of the dispatched instruction |
| robEmpty | input | NUM_THREADS | Reorder buffer holds nothing for the thread |
| robHeadSeq | input | NUM_THREADS*SEQ_W | Sequence number at the reorder buffer head |
| lastCommitSeq | input | NUM_THREADS*SEQ_W | Last committed sequence number |
| robDoneSquashing | input | NUM_THREADS | Reorder buffer has finished its squash walk |
| squashOut | output | NUM_THREADS | One-cycle squash pulse to earlier stages |
| robSquashing | output | NUM_THREADS | Reorder buffer squash in progress |
| doneSeq | output | NUM_THREADS*SEQ_W | Sequence number through which work is kept |
| branchTaken | output | NUM_THREADS | Branch-taken hint sent with the squash |
| threadStatus | output | NUM_THREADS*3 | Per-thread state code |
| trapInFlight | output | NUM_THREADS | Trap countdown outstanding |
| mispredCount | output | CNT_W | Number of accepted unconditional mispredict squashes |

## Verification
The hardest case to reach is a collision of sources in a single cycle. Examples are a context squash landing on the same edge as a pending squash-after and a valid execute squash, or a context request arriving while a zero-latency trap is about to fire. The stimulus builds these collisions on purpose. It parks a thread in SquashAfterPending and raises the context request on the same edge. It then holds an older execute squash steady across several edges, so the source that wins each edge shows up in the done sequence number. A later phase drives random requests against a behavioural model so that further overlaps occur without being scripted.

// File: rtl/squash_arb_pkg.sv
package squash_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_ROBSQ   = 3'd2,
    ST_TRAP    = 3'd3,
    ST_FTRAP   = 3'd4,
    ST_SQAFTER = 3'd5
  } thr_state_e;

  // control -> datapath strobes, one per thread
  typedef struct packed {
    logic doAll;    // whole-thread squash taken this cycle
    logic doExe;    // execute-stage squash accepted this cycle
    logic robBusy;  // reorder buffer still walking its squash
  } sq_strobe_t;

endpackage

// File: rtl/squash_arb_ctrl.sv
module squash_arb_ctrl
  import squash_arb_pkg::*;
#(
  parameter int NT    = 2,
  parameter int LAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LAT_W-1:0]  trapLatency,
  input  logic [NT-1:0]     faultValid,
  input  logic [NT-1:0]     ctxSquashReq,
  input  logic [NT-1:0]     squashAfterReq,
  input  logic [NT-1:0]     exeSquash,
  input  logic [NT-1:0]     exeOlder,
  input  logic [NT-1:0]     dispValid,
  input  logic [NT-1:0]     robDoneSquashing,
  output sq_strobe_t        strobe [NT],
  output logic [NT-1:0]     trapInFlight,
  output logic [NT*3-1:0]   stateFlat
);

  localparam logic [LAT_W-1:0] LAT_ONE = {{(LAT_W-1){1'b0}}, 1'b1};

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thr_state_e       st, effSt, stNext;
    logic             trapFlag, ctxFlag, inFlight;
    logic [LAT_W-1:0] timer;
    logic             actTrap, actCtx, actSa, doAll, doExe, robBusy, faultAcc;

    always_comb begin
      robBusy  = (st == ST_ROBSQ) && !robDoneSquashing[t];
      effSt    = (st == ST_ROBSQ && robDoneSquashing[t]) ? ST_RUN : st;
      actTrap  = trapFlag;
      actCtx   = !trapFlag && ctxFlag;
      actSa    = !trapFlag && !ctxFlag && (effSt == ST_SQAFTER);
      doAll    = actTrap || actCtx || actSa;
      doExe    = !doAll && exeSquash[t] && exeOlder[t] && (effSt != ST_TRAP);
      faultAcc = faultValid[t] && !inFlight;
      stNext   = effSt;
      if (faultAcc)                                stNext = ST_TRAP;
      else if (doAll || doExe)                     stNext = ST_ROBSQ;
      else if (effSt == ST_IDLE && dispValid[t])   stNext = ST_RUN;
      else if (effSt == ST_RUN && squashAfterReq[t]) stNext = ST_SQAFTER;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st       <= ST_IDLE;
        trapFlag <= 1'b0;
        ctxFlag  <= 1'b0;
        inFlight <= 1'b0;
        timer    <= '0;
      end else begin
        st      <= stNext;
        ctxFlag <= (ctxFlag && !actCtx) ||
                   (ctxSquashReq[t] && !inFlight && !faultValid[t]);
        if (actTrap) begin
          trapFlag <= 1'b0;
          inFlight <= 1'b0;
        end else if (faultAcc) begin
          inFlight <= 1'b1;
          timer    <= trapLatency;
        end else if (inFlight) begin
          if (timer == '0) trapFlag <= 1'b1;
          else             timer    <= timer - LAT_ONE;
        end
      end
    end

    assign strobe[t].doAll   = doAll;
    assign strobe[t].doExe   = doExe;
    assign strobe[t].robBusy = robBusy;
    assign trapInFlight[t]   = inFlight;
    assign stateFlat[t*3 +: 3] = st;

    // R4 / R5: trap and context requests are never pending together
    p_trap_ctx_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
      !(trapFlag && ctxFlag));

    // R3: a trap squash is only raised while the trap is in flight
    p_trap_flag_inflight_r3: assert property (@(posedge clk) disable iff (!rstN)
      trapFlag |-> inFlight);

    // R6: no execute squash accepted while the trap is pending
    p_trap_blocks_exe_r6: assert property (@(posedge clk) disable iff (!rstN)
      (st == ST_TRAP) |-> !doExe);

    // R5: a context request during a trap leaves no context request pending
    p_ctx_dropped_r5: assert property (@(posedge clk) disable iff (!rstN)
      (inFlight && ctxSquashReq[t]) |=> !ctxFlag);
  end

endmodule

// File: rtl/squash_arb_dp.sv
module squash_arb_dp
  import squash_arb_pkg::*;
#(
  parameter int NT    = 2,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  sq_strobe_t          strobe [NT],
  input  logic [NT*SEQ_W-1:0] exeSeq,
  input  logic [NT-1:0]       exeIncludeSelf,
  input  logic [NT-1:0]       exeMispredict,
  input  logic [NT-1:0]       exeUncond,
  input  logic [NT-1:0]       exeBranchTaken,
  input  logic [NT-1:0]       dispValid,
  input  logic [NT*SEQ_W-1:0] dispSeq,
  input  logic [NT-1:0]       robEmpty,
  input  logic [NT*SEQ_W-1:0] robHeadSeq,
  input  logic [NT*SEQ_W-1:0] lastCommitSeq,
  output logic [NT-1:0]       exeOlder,
  output logic [NT-1:0]       squashOut,
  output logic [NT-1:0]       robSquashing,
  output logic [NT*SEQ_W-1:0] doneSeq,
  output logic [NT-1:0]       branchTaken,
  output logic [CNT_W-1:0]    mispredCount
);

  localparam logic [SEQ_W-1:0] SEQ_ONE = {{(SEQ_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_NT  = CNT_W'(NT);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [SEQ_W-1:0] youngest, seqIn, exeEff, allSeq, lastSeq, doneR;
    logic             sqR, robR, brR;

    assign seqIn   = exeSeq[t*SEQ_W +: SEQ_W];
    assign lastSeq = lastCommitSeq[t*SEQ_W +: SEQ_W];
    assign exeEff  = exeIncludeSelf[t] ? (seqIn - SEQ_ONE) : seqIn;
    assign allSeq  = robEmpty[t] ? lastSeq
                                 : (robHeadSeq[t*SEQ_W +: SEQ_W] - SEQ_ONE);
    assign exeOlder[t] = (seqIn <= youngest);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        youngest <= '0;
        doneR    <= '0;
        sqR      <= 1'b0;
        robR     <= 1'b0;
        brR      <= 1'b0;
      end else if (strobe[t].doAll) begin
        youngest <= lastSeq;
        doneR    <= allSeq;
        sqR      <= 1'b1;
        robR     <= 1'b1;
        brR      <= 1'b0;
      end else if (strobe[t].doExe) begin
        youngest <= exeEff;
        doneR    <= exeEff;
        sqR      <= 1'b1;
        robR     <= 1'b1;
        brR      <= exeBranchTaken[t] || (exeMispredict[t] && exeUncond[t]);
      end else begin
        if (dispValid[t]) youngest <= dispSeq[t*SEQ_W +: SEQ_W];
        sqR  <= 1'b0;
        robR <= strobe[t].robBusy;
        brR  <= 1'b0;
      end
    end

    assign squashOut[t]              = sqR;
    assign robSquashing[t]           = robR;
    assign branchTaken[t]            = brR;
    assign doneSeq[t*SEQ_W +: SEQ_W] = doneR;
  end

  logic [CNT_W-1:0] incr;
  always_comb begin
    incr = '0;
    for (int t = 0; t < NT; t++)
      if (strobe[t].doExe && exeMispredict[t] && exeUncond[t]) incr = incr + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) mispredCount <= '0;
    else       mispredCount <= mispredCount + incr;
  end

  // R9: the mispredict count never grows by more than one per thread per cycle
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mispredCount - $past(mispredCount)) <= CNT_NT);

endmodule

// File: rtl/commit_squash_arb.sv
module commit_squash_arb
  import squash_arb_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  parameter int LAT_W       = 8,
  parameter int CNT_W       = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [LAT_W-1:0]             trapLatency,
  input  logic [NUM_THREADS-1:0]       faultValid,
  input  logic [NUM_THREADS-1:0]       ctxSquashReq,
  input  logic [NUM_THREADS-1:0]       squashAfterReq,
  input  logic [NUM_THREADS-1:0]       exeSquash,
  input  logic [NUM_THREADS*SEQ_W-1:0] exeSeq,
  input  logic [NUM_THREADS-1:0]       exeIncludeSelf,
  input  logic [NUM_THREADS-1:0]       exeMispredict,
  input  logic [NUM_THREADS-1:0]       exeUncond,
  input  logic [NUM_THREADS-1:0]       exeBranchTaken,
  input  logic [NUM_THREADS-1:0]       dispValid,
  input  logic [NUM_THREADS*SEQ_W-1:0] dispSeq,
  input  logic [NUM_THREADS-1:0]       robEmpty,
  input  logic [NUM_THREADS*SEQ_W-1:0] robHeadSeq,
  input  logic [NUM_THREADS*SEQ_W-1:0] lastCommitSeq,
  input  logic [NUM_THREADS-1:0]       robDoneSquashing,
  output logic [NUM_THREADS-1:0]       squashOut,
  output logic [NUM_THREADS-1:0]       robSquashing,
  output logic [NUM_THREADS*SEQ_W-1:0] doneSeq,
  output logic [NUM_THREADS-1:0]       branchTaken,
  output logic [NUM_THREADS*3-1:0]     threadStatus,
  output logic [NUM_THREADS-1:0]       trapInFlight,
  output logic [CNT_W-1:0]             mispredCount
);

  sq_strobe_t             strobe [NUM_THREADS];
  logic [NUM_THREADS-1:0] exeOlder;

  squash_arb_ctrl #(.NT(NUM_THREADS), .LAT_W(LAT_W)) u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .trapLatency      (trapLatency),
    .faultValid       (faultValid),
    .ctxSquashReq     (ctxSquashReq),
    .squashAfterReq   (squashAfterReq),
    .exeSquash        (exeSquash),
    .exeOlder         (exeOlder),
    .dispValid        (dispValid),
    .robDoneSquashing (robDoneSquashing),
    .strobe           (strobe),
    .trapInFlight     (trapInFlight),
    .stateFlat        (threadStatus)
  );

  squash_arb_dp #(.NT(NUM_THREADS), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .exeSeq         (exeSeq),
    .exeIncludeSelf (exeIncludeSelf),
    .exeMispredict  (exeMispredict),
    .exeUncond      (exeUncond),
    .exeBranchTaken (exeBranchTaken),
    .dispValid      (dispValid),
    .dispSeq        (dispSeq),
    .robEmpty       (robEmpty),
    .robHeadSeq     (robHeadSeq),
    .lastCommitSeq  (lastCommitSeq),
    .exeOlder       (exeOlder),
    .squashOut      (squashOut),
    .robSquashing   (robSquashing),
    .doneSeq        (doneSeq),
    .branchTaken    (branchTaken),
    .mispredCount   (mispredCount)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R11: an unfinished reorder buffer squash keeps the squashing flag up
    p_rob_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
      (threadStatus[t*3 +: 3] == 3'(ST_ROBSQ) && !robDoneSquashing[t])
      |=> robSquashing[t]);
  end

endmodule

// File: tb/commit_squash_arb_test.sv
module commit_squash_arb_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [7:0]  lat = 8'd0;
  logic [1:0]  faultV = '0, ctxR = '0, saR = '0, exeV = '0, exeI = '0;
  logic [1:0]  exeM = '0, exeU = '0, exeT = '0, dispV = '0, robE = 2'b11, robD = 2'b11;
  logic [15:0] exeS [2], dispS [2], robH [2], lastC [2];

  logic [1:0]  squashOut, robSquashing, branchTaken, trapInFlight;
  logic [31:0] doneSeq;
  logic [5:0]  threadStatus;
  logic [15:0] mispredCount;

  commit_squash_arb uut (
    .clk(clk), .rstN(rstN), .trapLatency(lat), .faultValid(faultV),
    .ctxSquashReq(ctxR), .squashAfterReq(saR), .exeSquash(exeV),
    .exeSeq({exeS[1], exeS[0]}), .exeIncludeSelf(exeI), .exeMispredict(exeM),
    .exeUncond(exeU), .exeBranchTaken(exeT), .dispValid(dispV),
    .dispSeq({dispS[1], dispS[0]}), .robEmpty(robE),
    .robHeadSeq({robH[1], robH[0]}), .lastCommitSeq({lastC[1], lastC[0]}),
    .robDoneSquashing(robD), .squashOut(squashOut), .robSquashing(robSquashing),
    .doneSeq(doneSeq), .branchTaken(branchTaken), .threadStatus(threadStatus),
    .trapInFlight(trapInFlight), .mispredCount(mispredCount)
  );

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, one slot per thread
  int mSt [2], mTimer [2], mYoung [2], mDone [2], mCnt;
  bit mFlag [2], mCtx [2], mInfl [2], mSq [2], mRob [2], mBr [2];

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      for (int t = 0; t < 2; t++) begin
        mSt[t] = 0; mTimer[t] = 0; mYoung[t] = 0; mDone[t] = 0;
        mFlag[t] = 0; mCtx[t] = 0; mInfl[t] = 0; mSq[t] = 0; mRob[t] = 0; mBr[t] = 0;
      end
    end else begin
      for (int t = 0; t < 2; t++) begin
        int s, eff;
        bit busy, takeAll, takeCtx, takeExe, newFault;
        s = mSt[t]; busy = 0;
        if (s == 2) begin
          if (robD[t]) s = 1; else busy = 1;
        end
        takeCtx  = !mFlag[t] && mCtx[t];
        takeAll  = mFlag[t] || mCtx[t] || (s == 5);
        takeExe  = !takeAll && exeV[t] && (int'(exeS[t]) <= mYoung[t]) && (s != 3);
        newFault = faultV[t] && !mInfl[t];
        mSq[t] = takeAll || takeExe;
        mRob[t] = takeAll || takeExe || busy;
        mBr[t] = 0;
        if (takeAll) begin
          mDone[t] = robE[t] ? int'(lastC[t]) : ((int'(robH[t]) - 1) & 16'hFFFF);
          mYoung[t] = int'(lastC[t]);
        end else if (takeExe) begin
          eff = exeI[t] ? ((int'(exeS[t]) - 1) & 16'hFFFF) : int'(exeS[t]);
          mDone[t] = eff;
          mYoung[t] = eff;
          mBr[t] = exeT[t] || (exeM[t] && exeU[t]);
          if (exeM[t] && exeU[t]) mCnt = (mCnt + 1) & 16'hFFFF;
        end else if (dispV[t]) begin
          mYoung[t] = int'(dispS[t]);
        end
        mCtx[t] = (mCtx[t] && !takeCtx) || (ctxR[t] && !mInfl[t] && !faultV[t]);
        if (mFlag[t]) begin
          mFlag[t] = 0; mInfl[t] = 0;
        end else if (newFault) begin
          mInfl[t] = 1; mTimer[t] = int'(lat);
        end else if (mInfl[t]) begin
          if (mTimer[t] == 0) mFlag[t] = 1; else mTimer[t]--;
        end
        if (newFault) s = 3;
        else if (takeAll || takeExe) s = 2;
        else if (s == 0 && dispV[t]) s = 1;
        else if (s == 1 && saR[t]) s = 5;
        mSt[t] = s;
      end
    end
  end

  task automatic compareAll();
    for (int t = 0; t < 2; t++) begin
      chk("R2 status", int'(threadStatus[t*3 +: 3]), mSt[t]);
      chk("R4 squash", int'(squashOut[t]), int'(mSq[t]));
      chk("R11 robSquashing", int'(robSquashing[t]), int'(mRob[t]));
      chk("R8 doneSeq", int'(doneSeq[t*16 +: 16]), mDone[t]);
      chk("R9 branchTaken", int'(branchTaken[t]), int'(mBr[t]));
      chk("R3 trapInFlight", int'(trapInFlight[t]), int'(mInfl[t]));
    end
    chk("R9 count", int'(mispredCount), mCnt);
  endtask

  task automatic tick();
    @(negedge clk);
    compareAll();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < 2; t++) begin
      exeS[t] = '0; dispS[t] = '0; robH[t] = '0; lastC[t] = 16'd7;
    end
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk("R1 status0", int'(threadStatus[2:0]), 0);
    chk("R1 status1", int'(threadStatus[5:3]), 0);
    chk("R1 squash", int'(squashOut), 0);
    chk("R1 count", int'(mispredCount), 0);

    // R2 / R12: dispatch moves thread 0 to Running, youngest 20
    dispV[0] = 1; dispS[0] = 16'd20; tick(); dispV[0] = 0;
    chk("R2 running", int'(threadStatus[2:0]), 1);
    // R6: younger than youngest is dropped
    exeV[0] = 1; exeS[0] = 16'd25; tick();
    chk("R6 younger dropped", int'(squashOut[0]), 0);
    // R8: accepted
    exeS[0] = 16'd18; tick(); exeV[0] = 0;
    chk("R8 squash", int'(squashOut[0]), 1);
    chk("R8 doneSeq", int'(doneSeq[15:0]), 18);
    chk("R8 state", int'(threadStatus[2:0]), 2);
    // R11: hold until the buffer is done
    robD[0] = 0; tick(); tick();
    chk("R11 hold", int'(robSquashing[0]), 1);
    chk("R11 no pulse", int'(squashOut[0]), 0);
    robD[0] = 1; tick();
    chk("R11 release state", int'(threadStatus[2:0]), 1);
    chk("R11 release flag", int'(robSquashing[0]), 0);
    // R7: include-self
    exeV[0] = 1; exeS[0] = 16'd15; exeI[0] = 1; tick();
    chk("R7 minus one", int'(doneSeq[15:0]), 14);
    exeI[0] = 0; tick();
    chk("R6 15 above 14 dropped", int'(squashOut[0]), 0);
    // R9: unconditional mispredict
    exeS[0] = 16'd10; exeM[0] = 1; exeU[0] = 1; tick();
    chk("R9 forced taken", int'(branchTaken[0]), 1);
    chk("R9 counted", int'(mispredCount), 1);
    exeS[0] = 16'd9; exeU[0] = 0; tick();
    chk("R9 conditional not forced", int'(branchTaken[0]), 0);
    chk("R9 not counted", int'(mispredCount), 1);
    exeM[0] = 0;

    // R3: trap with latency 3, execute squash blocked while pending
    lat = 8'd3; robE[0] = 1; lastC[0] = 16'd7;
    faultV[0] = 1; exeS[0] = 16'd5; tick(); faultV[0] = 0;
    chk("R3 in flight", int'(trapInFlight[0]), 1);
    chk("R3 trap state", int'(threadStatus[2:0]), 3);
    repeat (3) begin
      tick();
      chk("R6 blocked in trap", int'(squashOut[0]), 0);
    end
    exeV[0] = 0; tick();
    chk("R3 not yet", int'(squashOut[0]), 0);
    tick();
    chk("R3 fires", int'(squashOut[0]), 1);
    chk("R3 cleared", int'(trapInFlight[0]), 0);
    chk("R10 empty uses last commit", int'(doneSeq[15:0]), 7);

    // R4: context beats squash-after and execute
    saR[0] = 1; ctxR[0] = 1; tick(); saR[0] = 0; ctxR[0] = 0;
    chk("R2 squash-after state", int'(threadStatus[2:0]), 5);
    exeV[0] = 1; exeS[0] = 16'd3; tick();
    chk("R4 context wins", int'(doneSeq[15:0]), 7);
    tick();
    chk("R4 execute next", int'(doneSeq[15:0]), 3);
    exeV[0] = 0; tick();

    // R10: whole-thread squash on thread 1
    robE[1] = 0; robH[1] = 16'd50; lastC[1] = 16'd33;
    ctxR[1] = 1; tick(); ctxR[1] = 0; tick();
    chk("R10 head minus one", int'(doneSeq[31:16]), 49);
    robE[1] = 1; ctxR[1] = 1; tick(); ctxR[1] = 0; tick();
    chk("R10 last commit", int'(doneSeq[31:16]), 33);

    // R5 and zero latency
    lat = 8'd0; faultV[1] = 1; tick(); faultV[1] = 0;
    ctxR[1] = 1; tick(); ctxR[1] = 0; tick();
    chk("R3 zero latency fires", int'(squashOut[1]), 1);
    tick();
    chk("R5 context dropped", int'(squashOut[1]), 0);

    // R12: dispatch extends youngest
    exeV[1] = 1; exeS[1] = 16'd90; tick(); exeV[1] = 0;
    chk("R12 before dispatch", int'(squashOut[1]), 0);
    dispV[1] = 1; dispS[1] = 16'd100; tick(); dispV[1] = 0;
    exeV[1] = 1; tick(); exeV[1] = 0;
    chk("R12 after dispatch", int'(squashOut[1]), 1);
    chk("R12 doneSeq", int'(doneSeq[31:16]), 90);

    // mixed traffic against the model
    for (int i = 0; i < 400; i++) begin
      lat = 8'($urandom % 4);
      for (int t = 0; t < 2; t++) begin
        faultV[t] = ($urandom % 20) == 0;
        ctxR[t]   = ($urandom % 12) == 0;
        saR[t]    = ($urandom % 8) == 0;
        exeV[t]   = ($urandom % 3) == 0;
        exeS[t]   = 16'($urandom % 128);
        exeI[t]   = 1'($urandom);
        exeM[t]   = 1'($urandom);
        exeU[t]   = 1'($urandom);
        exeT[t]   = 1'($urandom);
        dispV[t]  = ($urandom % 3) == 0;
        dispS[t]  = 16'($urandom % 128);
        robE[t]   = 1'($urandom);
        robH[t]   = 16'($urandom % 128);
        lastC[t]  = 16'($urandom % 128);
        robD[t]   = ($urandom % 3) != 0;
      end
      tick();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule